// File: doc/BRIEF.md
# Exclusive Two-Level Tag Directory

This block tracks which line addresses sit in a small set-associative first-level data cache and in a larger set-associative second level. It holds tags and state flags only, never data. The two levels are kept exclusive: a line lives in one level or the other. For each request (a byte address plus a read/write flag) the directory classifies the access as a first-level hit, a second-level hit or a miss in both. It also reports the latency in cycles to charge the access and updates its tag state.

Requests arrive one at a time over a valid/ready handshake. The block walks the request through a short state sequence:
- first-level lookup and allocation;
- insertion of a displaced first-level line into the second level;
- second-level lookup.

It then raises a one-cycle done pulse carrying the result. Geometry and latencies are parameters. The defaults are scaled down for simulation. A full-size second level of 256 KB with 32-byte lines and 16 ways is reached by setting the set count to 512.

Top module: `tagdir_top`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0, all three counters read 0 and every way of both levels is invalid.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the result is delivered. `done` is high for exactly one cycle per request.
- R3: A first-level hit reports `res_kind` = 0 (0 = first-level hit, 1 = second-level hit, 2 = miss in both) with latency L1_HIT_LAT (default 1). A write hit sets that line's dirty flag.
- R4: On a miss in either level's allocation, the highest-numbered invalid way in the set is used. If every way is valid, the way is a 16-bit LFSR value modulo the way count. The LFSR is seeded with 0xACE1 at reset. It steps once per pseudo-random pick: shift right, and if the bit shifted out was 1, XOR with 0xB400. First-level and second-level picks share this one LFSR.
- R5: A first-level miss allocates the requested line in the first level, dirty on a write and clean on a read.
- R6: A line displaced from a full first-level set is rebuilt from its tag and set index. It is written into the second level with its dirty flag kept. This insertion happens before the requested line is looked up in the second level.
- R7: If the second-level way picked pseudo-randomly to receive a displaced line is dirty, MEM_WR_LAT (default 55) is added to the latency and `res_wb` is 1. Otherwise `res_wb` is 0.
- R8: A second-level hit reports `res_kind` = 1 with latency L1_MISS_LAT + L2_LAT (defaults 1 + 14). A read hit invalidates the second-level line and clears its dirty flag. A write hit leaves it in place.
- R9: A miss in both levels reports `res_kind` = 2 with latency L1_MISS_LAT + L2_LAT + MEM_RD_LAT (default 70), and nothing is allocated in the second level for the requested line.
- R10: Three 32-bit counters count first-level hits, second-level hits and misses. Exactly one of them increases by one per request, visible in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory idle, can take a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| done | output | 1 | One-cycle result strobe |
| res_kind | output | 2 | 0 first-level hit, 1 second-level hit, 2 miss |
| res_latency | output | LAT_W | Cycles charged to the access |
| res_wb | output | 1 | A dirty second-level line was written back |
| cnt_l1_hit | output | CNT_W | First-level hit count |
| cnt_l2_hit | output | CNT_W | Second-level hit count |
| cnt_miss | output | CNT_W | Miss count |

## Verification
The checker watches the handshake and the done strobe on every cycle. It also watches the fixed latency of a first-level hit, the latency arithmetic of second-level hits and misses including the write-back charge, and the one-step advance of the counter total. Which way is chosen, where a displaced line lands, how dirty state travels between levels and the invalidation on a read hit leave no trace in a single cycle. Only the bench's reference model shows them, by following long request streams whose later results depend on that state.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef enum logic [1:0] {
    KIND_L1   = 2'd0,
    KIND_L2   = 2'd1,
    KIND_MISS = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_L1   = 3'd1,
    ST_INS  = 3'd2,
    ST_L2   = 3'd3,
    ST_DONE = 3'd4
  } state_e;

endpackage

// File: rtl/tagdir_lfsr.sv
module tagdir_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] SEED = 16'hACE1,
  parameter logic [15:0] MASK = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value
);

  logic [W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (step) begin
      lfsr_d = lfsr_q >> 1;
      if (lfsr_q[0]) lfsr_d = lfsr_d ^ W'(MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lfsr_q <= W'(SEED);
    else if (step) lfsr_q <= lfsr_d;
  end

  assign value = lfsr_q;

endmodule

// File: rtl/tagdir_store.sv
module tagdir_store #(
  parameter  int SETS  = 4,
  parameter  int WAYS  = 2,
  parameter  int TAG_W = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [WAYS-1:0]            rd_valid,
  output logic [WAYS-1:0]            rd_dirty,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic                       wr_valid,
  input  logic                       wr_dirty
);

  logic [SETS-1:0][WAYS-1:0]            valid_q;
  logic [SETS-1:0][WAYS-1:0]            dirty_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx][wr_way] <= wr_valid;
      dirty_q[wr_idx][wr_way] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx][wr_way] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/tagdir_waysel.sv
module tagdir_waysel #(
  parameter  int WAYS  = 2,
  parameter  int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           look_tag,
  input  logic [WAY_W-1:0]           rnd_way,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       any_free,
  output logic [WAY_W-1:0]           pick_way
);

  logic [WAYS-1:0] match;
  logic [WAY_W-1:0] free_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid[w] && (tags[w] == look_tag);
  end

  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    any_free = 1'b0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w] && !hit) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!valid[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    pick_way = any_free ? free_way : rnd_way;
  end

endmodule

// File: rtl/tagdir_top.sv
module tagdir_top #(
  parameter int          ADDR_W      = 32,
  parameter int          LINE_BYTES  = 32,
  parameter int          L1_SETS     = 4,
  parameter int          L1_WAYS     = 2,
  parameter int          L2_SETS     = 8,
  parameter int          L2_WAYS     = 4,
  parameter int          LAT_W       = 8,
  parameter int          CNT_W       = 32,
  parameter int          L1_HIT_LAT  = 1,
  parameter int          L1_MISS_LAT = 1,
  parameter int          L2_LAT      = 14,
  parameter int          MEM_RD_LAT  = 55,
  parameter int          MEM_WR_LAT  = 55,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              done,
  output logic [1:0]        res_kind,
  output logic [LAT_W-1:0]  res_latency,
  output logic              res_wb,
  output logic [CNT_W-1:0]  cnt_l1_hit,
  output logic [CNT_W-1:0]  cnt_l2_hit,
  output logic [CNT_W-1:0]  cnt_miss
);
  import tagdir_pkg::*;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int I1_W   = $clog2(L1_SETS);
  localparam int T1_W   = LINE_W - I1_W;
  localparam int W1_W   = $clog2(L1_WAYS);
  localparam int I2_W   = $clog2(L2_SETS);
  localparam int T2_W   = LINE_W - I2_W;
  localparam int W2_W   = $clog2(L2_WAYS);

  state_e             state_q, state_d;
  logic [LINE_W-1:0]  line_q, line_d;
  logic               wr_q, wr_d;
  logic [LINE_W-1:0]  vline_q, vline_d;
  logic               vdirty_q, vdirty_d;
  logic [LAT_W-1:0]   lat_q, lat_d;
  kind_e              kind_q, kind_d;
  logic               wb_q, wb_d;
  logic [CNT_W-1:0]   c1_q, c1_d, c2_q, c2_d, cm_q, cm_d;
  logic               take_req;

  logic               lfsr_step;
  logic [15:0]        lfsr_val;

  logic [L1_WAYS-1:0]            l1_rd_valid, l1_rd_dirty;
  logic [L1_WAYS-1:0][T1_W-1:0]  l1_rd_tag;
  logic                          l1_we, l1_wdirty;
  logic [W1_W-1:0]               l1_wway, l1_rnd, l1_hit_way, l1_pick;
  logic                          l1_hit, l1_free;

  logic [L2_WAYS-1:0]            l2_rd_valid, l2_rd_dirty;
  logic [L2_WAYS-1:0][T2_W-1:0]  l2_rd_tag;
  logic                          l2_we, l2_wvalid, l2_wdirty;
  logic [W2_W-1:0]               l2_wway, l2_rnd, l2_hit_way, l2_pick;
  logic                          l2_hit, l2_free;
  logic [LINE_W-1:0]             l2_line;

  logic unused_offset;
  assign unused_offset = ^req_addr[OFF_W-1:0];

  tagdir_lfsr #(.W(16), .SEED(LFSR_SEED), .MASK(16'hB400)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(lfsr_step), .value(lfsr_val)
  );

  assign l1_rnd = W1_W'(int'(lfsr_val) % L1_WAYS);
  assign l2_rnd = W2_W'(int'(lfsr_val) % L2_WAYS);

  tagdir_store #(.SETS(L1_SETS), .WAYS(L1_WAYS), .TAG_W(T1_W)) u_l1_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(line_q[I1_W-1:0]),
    .rd_valid(l1_rd_valid), .rd_dirty(l1_rd_dirty), .rd_tag(l1_rd_tag),
    .wr_en(l1_we), .wr_idx(line_q[I1_W-1:0]), .wr_way(l1_wway),
    .wr_tag(line_q[LINE_W-1:I1_W]), .wr_valid(1'b1), .wr_dirty(l1_wdirty)
  );

  tagdir_waysel #(.WAYS(L1_WAYS), .TAG_W(T1_W)) u_l1_sel (
    .valid(l1_rd_valid), .tags(l1_rd_tag), .look_tag(line_q[LINE_W-1:I1_W]),
    .rnd_way(l1_rnd), .hit(l1_hit), .hit_way(l1_hit_way),
    .any_free(l1_free), .pick_way(l1_pick)
  );

  // second level addresses the displaced line while inserting it
  assign l2_line = (state_q == ST_INS) ? vline_q : line_q;

  tagdir_store #(.SETS(L2_SETS), .WAYS(L2_WAYS), .TAG_W(T2_W)) u_l2_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(l2_line[I2_W-1:0]),
    .rd_valid(l2_rd_valid), .rd_dirty(l2_rd_dirty), .rd_tag(l2_rd_tag),
    .wr_en(l2_we), .wr_idx(l2_line[I2_W-1:0]), .wr_way(l2_wway),
    .wr_tag(l2_line[LINE_W-1:I2_W]), .wr_valid(l2_wvalid), .wr_dirty(l2_wdirty)
  );

  tagdir_waysel #(.WAYS(L2_WAYS), .TAG_W(T2_W)) u_l2_sel (
    .valid(l2_rd_valid), .tags(l2_rd_tag), .look_tag(l2_line[LINE_W-1:I2_W]),
    .rnd_way(l2_rnd), .hit(l2_hit), .hit_way(l2_hit_way),
    .any_free(l2_free), .pick_way(l2_pick)
  );

  always_comb begin
    state_d   = state_q;
    line_d    = line_q;
    wr_d      = wr_q;
    vline_d   = vline_q;
    vdirty_d  = vdirty_q;
    lat_d     = lat_q;
    kind_d    = kind_q;
    wb_d      = wb_q;
    c1_d      = c1_q;
    c2_d      = c2_q;
    cm_d      = cm_q;
    take_req  = 1'b0;
    lfsr_step = 1'b0;
    l1_we     = 1'b0;
    l1_wway   = l1_pick;
    l1_wdirty = wr_q;
    l2_we     = 1'b0;
    l2_wway   = l2_pick;
    l2_wvalid = 1'b1;
    l2_wdirty = vdirty_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          take_req = 1'b1;
          line_d   = req_addr[ADDR_W-1:OFF_W];
          wr_d     = req_write;
          lat_d    = '0;
          wb_d     = 1'b0;
          state_d  = ST_L1;
        end
      end
      ST_L1: begin
        if (l1_hit) begin
          kind_d    = KIND_L1;
          lat_d     = LAT_W'(L1_HIT_LAT);
          l1_we     = wr_q;
          l1_wway   = l1_hit_way;
          l1_wdirty = 1'b1;
          state_d   = ST_DONE;
        end else begin
          l1_we = 1'b1;
          lat_d = LAT_W'(L1_MISS_LAT);
          if (!l1_free) begin
            lfsr_step = 1'b1;
            vline_d   = {l1_rd_tag[l1_pick], line_q[I1_W-1:0]};
            vdirty_d  = l1_rd_dirty[l1_pick];
            state_d   = ST_INS;
          end else begin
            state_d = ST_L2;
          end
        end
      end
      ST_INS: begin
        l2_we = 1'b1;
        if (!l2_free) begin
          lfsr_step = 1'b1;
          if (l2_rd_dirty[l2_pick]) begin
            wb_d  = 1'b1;
            lat_d = lat_q + LAT_W'(MEM_WR_LAT);
          end
        end
        state_d = ST_L2;
      end
      ST_L2: begin
        if (l2_hit) begin
          kind_d = KIND_L2;
          lat_d  = lat_q + LAT_W'(L2_LAT);
          if (!wr_q) begin
            l2_we     = 1'b1;
            l2_wway   = l2_hit_way;
            l2_wvalid = 1'b0;
            l2_wdirty = 1'b0;
          end
        end else begin
          kind_d = KIND_MISS;
          lat_d  = lat_q + LAT_W'(L2_LAT + MEM_RD_LAT);
        end
        state_d = ST_DONE;
      end
      ST_DONE: begin
        unique case (kind_q)
          KIND_L1: c1_d = c1_q + 1'b1;
          KIND_L2: c2_d = c2_q + 1'b1;
          default: cm_d = cm_q + 1'b1;
        endcase
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lat_q   <= '0;
      kind_q  <= KIND_L1;
      wb_q    <= 1'b0;
      c1_q    <= '0;
      c2_q    <= '0;
      cm_q    <= '0;
    end else begin
      state_q <= state_d;
      lat_q   <= lat_d;
      kind_q  <= kind_d;
      wb_q    <= wb_d;
      c1_q    <= c1_d;
      c2_q    <= c2_d;
      cm_q    <= cm_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take_req) begin
      line_q <= line_d;
      wr_q   <= wr_d;
    end
    if (state_q == ST_L1) begin
      vline_q  <= vline_d;
      vdirty_q <= vdirty_d;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign done        = (state_q == ST_DONE);
  assign res_kind    = kind_q;
  assign res_latency = lat_q;
  assign res_wb      = wb_q;
  assign cnt_l1_hit  = c1_q;
  assign cnt_l2_hit  = c2_q;
  assign cnt_miss    = cm_q;

endmodule

// File: rtl/tagdir_chk.sv
module tagdir_chk #(
  parameter int LAT_W       = 8,
  parameter int CNT_W       = 32,
  parameter int L1_HIT_LAT  = 1,
  parameter int L1_MISS_LAT = 1,
  parameter int L2_LAT      = 14,
  parameter int MEM_RD_LAT  = 55,
  parameter int MEM_WR_LAT  = 55
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done,
  input logic [1:0]       res_kind,
  input logic [LAT_W-1:0] res_latency,
  input logic             res_wb,
  input logic [CNT_W-1:0] cnt_l1_hit,
  input logic [CNT_W-1:0] cnt_l2_hit,
  input logic [CNT_W-1:0] cnt_miss
);

  logic [CNT_W+1:0] total;
  logic [LAT_W-1:0] wb_cost;
  assign total   = {2'b00, cnt_l1_hit} + {2'b00, cnt_l2_hit} + {2'b00, cnt_miss};
  assign wb_cost = res_wb ? LAT_W'(MEM_WR_LAT) : '0;

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready); // R2

  AST_L1_HIT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_kind == 2'd0) |-> (res_latency == LAT_W'(L1_HIT_LAT) && !res_wb)); // R3

  AST_L2_HIT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_kind == 2'd1) |-> (res_latency == LAT_W'(L1_MISS_LAT + L2_LAT) + wb_cost)); // R8

  AST_MISS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_kind == 2'd2) |-> (res_latency == LAT_W'(L1_MISS_LAT + L2_LAT + MEM_RD_LAT) + wb_cost)); // R9

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_kind != 2'd3); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> total == $past(total) + 1'b1); // R10

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(total)); // R10

endmodule

bind tagdir_top tagdir_chk #(
  .LAT_W(LAT_W), .CNT_W(CNT_W), .L1_HIT_LAT(L1_HIT_LAT), .L1_MISS_LAT(L1_MISS_LAT),
  .L2_LAT(L2_LAT), .MEM_RD_LAT(MEM_RD_LAT), .MEM_WR_LAT(MEM_WR_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .res_kind(res_kind), .res_latency(res_latency), .res_wb(res_wb),
  .cnt_l1_hit(cnt_l1_hit), .cnt_l2_hit(cnt_l2_hit), .cnt_miss(cnt_miss)
);

// File: tb/sim_tagdir_top.sv
`timescale 1ns/1ps
module sim_tagdir_top;

  localparam int L1S = 4, L1W = 2, L2S = 8, L2W = 4;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic        req_write;
  logic        done;
  logic [1:0]  res_kind;
  logic [7:0]  res_latency;
  logic        res_wb;
  logic [31:0] cnt_l1_hit, cnt_l2_hit, cnt_miss;

  tagdir_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .done(done), .res_kind(res_kind),
    .res_latency(res_latency), .res_wb(res_wb), .cnt_l1_hit(cnt_l1_hit),
    .cnt_l2_hit(cnt_l2_hit), .cnt_miss(cnt_miss)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  bit  m1v [L1S][L1W];
  bit  m1d [L1S][L1W];
  int  m1t [L1S][L1W];
  bit  m2v [L2S][L2W];
  bit  m2d [L2S][L2W];
  int  m2t [L2S][L2W];
  logic [15:0] mlfsr;
  int  mc1, mc2, mcm;
  int  seen_wb, seen_l2rd;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd_pick(input int ways);
    int r;
    r = int'(mlfsr) % ways;
    if (mlfsr[0]) mlfsr = (mlfsr >> 1) ^ 16'hB400;
    else          mlfsr = mlfsr >> 1;
    return r;
  endfunction

  task automatic model(input int line, input bit w, output int ek, output int el, output bit ewb);
    int i1, t1, i2, t2, way, vline;
    bit hit, have_v, vd;
    i1 = line % L1S; t1 = line / L1S;
    ewb = 0; hit = 0; have_v = 0; vd = 0; vline = 0;
    for (int k = 0; k < L1W; k++)
      if (!hit && m1v[i1][k] && m1t[i1][k] == t1) begin
        hit = 1;
        if (w) m1d[i1][k] = 1;
      end
    if (hit) begin ek = 0; el = 1; mc1++; return; end
    el = 1;
    way = -1;
    for (int k = 0; k < L1W; k++) if (!m1v[i1][k]) way = k;
    if (way < 0) begin
      way = rnd_pick(L1W);
      have_v = 1; vline = m1t[i1][way] * L1S + i1; vd = m1d[i1][way];
    end
    m1v[i1][way] = 1; m1t[i1][way] = t1; m1d[i1][way] = w;
    if (have_v) begin
      i2 = vline % L2S; t2 = vline / L2S;
      way = -1;
      for (int k = 0; k < L2W; k++) if (!m2v[i2][k]) way = k;
      if (way < 0) begin
        way = rnd_pick(L2W);
        if (m2d[i2][way]) begin ewb = 1; el += 55; end
      end
      m2v[i2][way] = 1; m2t[i2][way] = t2; m2d[i2][way] = vd;
    end
    i2 = line % L2S; t2 = line / L2S;
    hit = 0;
    for (int k = 0; k < L2W; k++)
      if (!hit && m2v[i2][k] && m2t[i2][k] == t2) begin
        hit = 1;
        if (!w) begin m2v[i2][k] = 0; m2d[i2][k] = 0; end
      end
    if (hit) begin ek = 1; el += 14; mc2++; end
    else     begin ek = 2; el += 69; mcm++; end
  endtask

  task automatic do_req(input int line, input bit w, output int ak, output int al);
    int ek, el, guard;
    bit ewb;
    model(line, w, ek, el, ewb);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_addr = 32'(line) << 5 | 32'(line % 7); req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 busy after take", int'(req_ready), 0);
    guard = 0;
    while (!done && guard < 40) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R2 done arrives", int'(done), 1);
    ak = int'(res_kind); al = int'(res_latency);
    chk(ak == ek, ek == 0 ? "R3 kind" : (ek == 1 ? "R8 kind" : "R9 kind"), ak, ek);
    chk(al == el, ek == 0 ? "R3 latency" : (ek == 1 ? "R8 latency" : "R9 latency"), al, el);
    chk(res_wb == ewb, "R7 write-back flag", int'(res_wb), int'(ewb));
    if (ewb) seen_wb++;
    if (ek == 1 && !w) seen_l2rd++;
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", int'(done), 0);
    chk(cnt_l1_hit == 32'(mc1) && cnt_l2_hit == 32'(mc2) && cnt_miss == 32'(mcm),
        "R10 counters", int'(cnt_l1_hit + cnt_l2_hit + cnt_miss), mc1 + mc2 + mcm);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
    end
  end

  initial begin
    int k, l;
    int s;
    s = int'($urandom(32'd20240611));
    mlfsr = 16'hACE1;
    mc1 = 0; mc2 = 0; mcm = 0; seen_wb = 0; seen_l2rd = 0;
    foreach (m1v[i, j]) begin m1v[i][j] = 0; m1d[i][j] = 0; m1t[i][j] = 0; end
    foreach (m2v[i, j]) begin m2v[i][j] = 0; m2d[i][j] = 0; m2t[i][j] = 0; end
    req_valid = 0; req_addr = '0; req_write = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(cnt_l1_hit == 0 && cnt_l2_hit == 0 && cnt_miss == 0, "R1 counters",
        int'(cnt_l1_hit + cnt_l2_hit + cnt_miss), 0);

    // directed: cold miss, hit, allocation, displacement, exclusive move
    do_req(0, 0, k, l); chk(k == 2 && l == 70, "R9 cold read miss", l, 70);
    do_req(0, 0, k, l); chk(k == 0 && l == 1, "R3 read hit", l, 1);
    do_req(4, 1, k, l); chk(k == 2 && l == 70, "R5 write allocate", l, 70);
    do_req(8, 1, k, l); chk(k == 2, "R4 random displacement", k, 2);
    do_req(0, 0, k, l); chk(k == 1 && l == 15, "R6 displaced line found in second level", l, 15);
    do_req(0, 0, k, l); chk(k == 0 && l == 1, "R8 line moved to first level", l, 1);
    do_req(4, 1, k, l); chk(k == 1 && l == 15, "R6 dirty line migrated", l, 15);
    do_req(4, 0, k, l); chk(k == 0, "R3 hit after move", k, 0);

    // constrained random stream over 64 lines
    for (int n = 0; n < 3000; n++) begin
      int line;
      bit w;
      line = int'($urandom_range(0, 63));
      w    = 1'($urandom_range(0, 1));
      do_req(line, w, k, l);
    end
    chk(seen_wb > 0, "R7 write-back observed", seen_wb, 1);
    chk(seen_l2rd > 0, "R8 read hit in second level observed", seen_l2rd, 1);
    finished = 1;
    report();
  end

endmodule